// File: doc/BRIEF.md
# Reloading Pulse Timer

A down-counting timer made of two cascaded stages: a prescaler that steps on a selected single-cycle clock-enable input, and a main counter that steps each time the prescaler passes zero. Each stage has its own reload register. When a stage steps from zero, it takes the value of its reload register and keeps counting. Each time the main counter passes zero, an internal toggle flips and a one-cycle interrupt request is raised. So the primary output completes one level change every (n+1)(m+1) selected ticks, where n is the prescaler reload and m is the main reload.

Software controls the timer through a small register port with four addresses: control, mode, prescaler and main counter. The mode register chooses the tick source and the level the output starts at. It also enables a complementary twin output and can gate the primary output to its start level. Reads of the two counter addresses return the live counts. All logic runs on one clock. The asynchronous active-low reset is released synchronously inside the block.

Top module: `rld_pulse_timer`

## Requirements
- R1: When the prescaler steps from 0 it loads its reload value, and otherwise it decrements. The main counter steps only in a cycle where the prescaler steps from 0, and it follows the same reload-or-decrement rule.
- R2: With the selected tick high every cycle, the primary output changes level every (n+1)(m+1) cycles. For example, n=2 and m=3 give 12.
- R3: `irq` is high in exactly the cycles where the main counter steps from 0. The primary output inverts in the following cycle.
- R4: Mode bits [1:0] at address 1 select which `tick_en` bit drives the prescaler. The other tick bits have no effect on the counts.
- R5: At address 0, writing 1 to bit 0 starts counting from the next cycle, and writing 0 stops it. While stopped, both counts hold. Reading address 0 returns the run state in bit 0.
- R6: Writing 1 to bit 1 at address 0 is a forced stop. It clears the run state even if bit 0 is also written as 1, reloads both live counts from their reload registers, and returns the toggle to the start level.
- R7: Writing the mode register sets the toggle to the new mode bit 2, the start level. That level shows on `pulse_out` in the next cycle, unless the output is gated.
- R8: While mode bit 3 is 1, `pulse_out_n` equals the inverse of `pulse_out`. While it is 0, `pulse_out_n` is 0.
- R9: While mode bit 4 is 1, `pulse_out` shows the start level. Underflows still raise `irq` during this time.
- R10: Writing address 2 (prescaler) or address 3 (main counter) while stopped sets both the reload register and the live count. While running, such a write sets only the reload register, and the live count picks up the new value at its next step from 0. A step from 0 in the same cycle as the write uses the previous reload value.
- R11: Reading address 2 returns the live prescaler count, and reading address 3 returns the live main count. Reads are combinational from the current state.
- R12: After reset, the timer is stopped and the mode is 0. Both reload registers and both counts are 0xFF, and `pulse_out`, `pulse_out_n` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | Single-cycle count-source enables |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 mode, 2 prescaler, 3 main) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pulse_out | output | 1 | Primary toggling output |
| pulse_out_n | output | 1 | Complementary twin output |
| irq | output | 1 | One-cycle interrupt request on main-counter underflow |

## Verification
Each result has a fixed due time:
- `irq` and `bus_rdata` are combinational. They are due in the same cycle as the inputs that cause them.
- Register writes, start and stop take effect at the next rising edge.
- The primary output changes in the cycle after the underflow that caused it.

The bench applies inputs at the falling edge and compares every output one time unit later against a behavioural model. The model holds the state as it was before the coming rising edge. The model advances at that rising edge with the same inputs. A measured edge-to-edge interval confirms the divide ratio.

// File: rtl/rpt_pkg.sv
`timescale 1ns/1ps
package rpt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_MODE = 2'd1,
    ADR_PRE  = 2'd2,
    ADR_MAIN = 2'd3
  } rpt_addr_e;

  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_HALT_BIT = 1;

  typedef struct packed {
    logic gate;
    logic twin;
    logic lvl;
  } mode_flags_t;
endpackage

// File: rtl/rpt_down_stage.sv
`timescale 1ns/1ps
module rpt_down_stage #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             running,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             force_reload,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic [CNT_W-1:0] rld_q, rld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;
  logic             direct_load;

  assign at_zero     = (cnt_q == '0);
  assign underflow   = step && at_zero;
  assign direct_load = wr && !running;

  always_comb begin
    rld_d = rld_q;
    if (wr) begin
      rld_d = wdata;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (force_reload) begin
      cnt_d = rld_q;
    end else if (direct_load) begin
      cnt_d = wdata;
    end else if (step) begin
      cnt_d = at_zero ? rld_q : (cnt_q - CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= RST_VAL;
      cnt_q <= RST_VAL;
    end else begin
      rld_q <= rld_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !force_reload && !direct_load) |=> (count == $past(rld_q))); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !force_reload && !direct_load) |=> (count == $past(count) - CNT_W'(1))); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr && !force_reload) |=> $stable(count)); // R5
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_load && !force_reload) |=> (count == $past(wdata))); // R10
endmodule

// File: rtl/rpt_ctrl_regs.sv
`timescale 1ns/1ps
module rpt_ctrl_regs
  import rpt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  localparam int LVL_POS  = SEL_W,
  localparam int TWIN_POS = SEL_W + 1,
  localparam int GATE_POS = SEL_W + 2,
  localparam int CFG_W    = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [DATA_W-1:0] pre_count,
  input  logic [DATA_W-1:0] main_count,
  output logic              run,
  output logic [SEL_W-1:0]  src_sel,
  output mode_flags_t       flags,
  output logic              halt,
  output logic              pre_wr,
  output logic              main_wr,
  output logic              lvl_load,
  output logic              lvl_load_val,
  output logic [DATA_W-1:0] bus_rdata
);
  logic        ctrl_wr, mode_wr;
  logic        run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  mode_flags_t flags_q, flags_d;

  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
    mode_wr = bus_wr && (bus_addr == ADR_MODE);
    pre_wr  = bus_wr && (bus_addr == ADR_PRE);
    main_wr = bus_wr && (bus_addr == ADR_MAIN);
    halt    = ctrl_wr && cfg_data[CTL_HALT_BIT];
  end

  always_comb begin
    run_d = run_q;
    if (halt) begin
      run_d = 1'b0;
    end else if (ctrl_wr) begin
      run_d = cfg_data[CTL_RUN_BIT];
    end
  end

  always_comb begin
    sel_d   = sel_q;
    flags_d = flags_q;
    if (mode_wr) begin
      sel_d        = cfg_data[SEL_W-1:0];
      flags_d.lvl  = cfg_data[LVL_POS];
      flags_d.twin = cfg_data[TWIN_POS];
      flags_d.gate = cfg_data[GATE_POS];
    end
  end

  always_comb begin
    lvl_load     = halt || mode_wr;
    lvl_load_val = mode_wr ? cfg_data[LVL_POS] : flags_q.lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= '0;
      flags_q <= '0;
    end else begin
      run_q   <= run_d;
      sel_q   <= sel_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (rpt_addr_e'(bus_addr))
      ADR_CTRL: bus_rdata[CTL_RUN_BIT] = run_q;
      ADR_MODE: begin
        bus_rdata[SEL_W-1:0] = sel_q;
        bus_rdata[LVL_POS]   = flags_q.lvl;
        bus_rdata[TWIN_POS]  = flags_q.twin;
        bus_rdata[GATE_POS]  = flags_q.gate;
      end
      ADR_PRE:  bus_rdata = pre_count;
      ADR_MAIN: bus_rdata = main_count;
      default:  bus_rdata = '0;
    endcase
  end

  assign run     = run_q;
  assign src_sel = sel_q;
  assign flags   = flags_q;

  AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !run); // R6
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !halt) |=> (run == $past(cfg_data[CTL_RUN_BIT]))); // R5
endmodule

// File: rtl/rpt_pulse_out.sv
`timescale 1ns/1ps
module rpt_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic main_uf,
  input  logic lvl_load,
  input  logic lvl_load_val,
  input  logic start_lvl,
  input  logic gate,
  input  logic twin,
  output logic pulse_out,
  output logic pulse_out_n
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (lvl_load) begin
      tog_d = lvl_load_val;
    end else if (main_uf) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  always_comb begin
    pulse_out   = gate ? start_lvl : tog_q;
    pulse_out_n = twin && !pulse_out;
  end

  AST_TOGGLE_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (main_uf && !lvl_load) |=> (tog_q != $past(tog_q))); // R3
  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_load |=> (tog_q == $past(lvl_load_val))); // R7
endmodule

// File: rtl/rld_pulse_timer.sv
`timescale 1ns/1ps
module rld_pulse_timer
  import rpt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CFG_W  = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pulse_out,
  output logic              pulse_out_n,
  output logic              irq
);
  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic              run, halt, pre_wr, main_wr, lvl_load, lvl_load_val;
  logic [SEL_W-1:0]  src_sel;
  mode_flags_t       flags;
  logic              src_tick, pre_step, pre_uf, main_uf;
  logic [DATA_W-1:0] pre_count, main_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync[1];

  rpt_ctrl_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .cfg_data     (bus_wdata[CFG_W-1:0]),
    .pre_count    (pre_count),
    .main_count   (main_count),
    .run          (run),
    .src_sel      (src_sel),
    .flags        (flags),
    .halt         (halt),
    .pre_wr       (pre_wr),
    .main_wr      (main_wr),
    .lvl_load     (lvl_load),
    .lvl_load_val (lvl_load_val),
    .bus_rdata    (bus_rdata)
  );

  assign src_tick = tick_en[src_sel];
  assign pre_step = run && src_tick;

  rpt_down_stage #(.CNT_W(DATA_W)) u_pre (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .step         (pre_step),
    .running      (run),
    .wr           (pre_wr),
    .wdata        (bus_wdata),
    .force_reload (halt),
    .count        (pre_count),
    .underflow    (pre_uf)
  );

  rpt_down_stage #(.CNT_W(DATA_W)) u_main (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .step         (pre_uf),
    .running      (run),
    .wr           (main_wr),
    .wdata        (bus_wdata),
    .force_reload (halt),
    .count        (main_count),
    .underflow    (main_uf)
  );

  rpt_pulse_out u_out (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .main_uf      (main_uf),
    .lvl_load     (lvl_load),
    .lvl_load_val (lvl_load_val),
    .start_lvl    (flags.lvl),
    .gate         (flags.gate),
    .twin         (flags.twin),
    .pulse_out    (pulse_out),
    .pulse_out_n  (pulse_out_n)
  );

  assign irq = main_uf;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    halt |=> !irq); // R6
  AST_MAIN_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (pre_count == '0)); // R1
endmodule

// File: tb/rld_pulse_timer_bench.sv
`timescale 1ns/1ps
module rld_pulse_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tick_en;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pulse_out, pulse_out_n, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;
  bit done     = 0;
  string cur_tag = "R12";

  int m_pre, m_cnt, m_rpre, m_rcnt, m_sel;
  bit m_run, m_lvl, m_twin, m_gate, m_tog;
  int cyc_n = 0, last_edge = 0, last_iv = 0;
  bit prev_pulse = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rld_pulse_timer u_rld_pulse_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pulse_out(pulse_out), .pulse_out_n(pulse_out_n), .irq(irq)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc_n);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 50000);
      summary();
      $finish;
    end
  end

  // One bus cycle: drive at falling edge, compare, advance model at rising edge.
  task automatic cyc(input bit wr, input int a, input int d, input logic [3:0] tk);
    bit e_tick, e_puf, e_muf, e_pulse, e_pn, halt, cw, mw;
    int e_rd, n_pre, n_cnt;
    bit n_run, n_tog;
    @(negedge clk);
    bus_wr = wr; bus_addr = 2'(a); bus_wdata = 8'(d); tick_en = tk;
    #1;
    e_tick  = m_run && tk[m_sel];
    e_puf   = e_tick && (m_pre == 0);
    e_muf   = e_puf && (m_cnt == 0);
    e_pulse = m_gate ? m_lvl : m_tog;
    e_pn    = m_twin ? !e_pulse : 1'b0;
    case (a)
      0: e_rd = int'(m_run);
      1: e_rd = m_sel + 4 * int'(m_lvl) + 8 * int'(m_twin) + 16 * int'(m_gate);
      2: e_rd = m_pre;
      default: e_rd = m_cnt;
    endcase
    check("R3", "irq", int'(irq), int'(e_muf));
    check(m_gate ? "R9" : "R3", "pulse_out", int'(pulse_out), int'(e_pulse));
    check("R8", "pulse_out_n", int'(pulse_out_n), int'(e_pn));
    check(cur_tag, "bus_rdata", int'(bus_rdata), e_rd);
    if (pulse_out != prev_pulse) begin
      last_iv = cyc_n - last_edge;
      last_edge = cyc_n;
    end
    prev_pulse = pulse_out;
    cyc_n++;
    @(posedge clk);
    halt = wr && a == 0 && d[1];
    cw   = wr && a == 0;
    mw   = wr && a == 1;
    if (halt) n_pre = m_rpre;
    else if (wr && a == 2 && !m_run) n_pre = d;
    else if (e_tick) n_pre = (m_pre == 0) ? m_rpre : m_pre - 1;
    else n_pre = m_pre;
    if (halt) n_cnt = m_rcnt;
    else if (wr && a == 3 && !m_run) n_cnt = d;
    else if (e_puf) n_cnt = (m_cnt == 0) ? m_rcnt : m_cnt - 1;
    else n_cnt = m_cnt;
    if (halt) n_tog = m_lvl;
    else if (mw) n_tog = d[2];
    else if (e_muf) n_tog = !m_tog;
    else n_tog = m_tog;
    n_run = halt ? 1'b0 : (cw ? d[0] : m_run);
    if (wr && a == 2) m_rpre = d;
    if (wr && a == 3) m_rcnt = d;
    if (mw) begin
      m_sel = d & 3; m_lvl = d[2]; m_twin = d[3]; m_gate = d[4];
    end
    m_pre = n_pre; m_cnt = n_cnt; m_tog = n_tog; m_run = n_run;
  endtask

  task automatic idle(input int n, input int a, input logic [3:0] tk);
    for (int i = 0; i < n; i++) cyc(0, a, 0, tk);
  endtask

  task automatic rnd(input int n, input int a);
    for (int i = 0; i < n; i++) cyc(0, (a < 0) ? (i % 4) : a, 0, 4'($urandom));
  endtask

  initial begin
    rst_n = 0; tick_en = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_pre = 255; m_cnt = 255; m_rpre = 255; m_rcnt = 255; m_sel = 0;
    m_run = 0; m_lvl = 0; m_twin = 0; m_gate = 0; m_tog = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    cur_tag = "R12";
    for (int a = 0; a < 4; a++) cyc(0, a, 0, 4'h0);

    cur_tag = "R10";                        // stopped writes load live counts
    cyc(1, 2, 2, 4'h0);
    cyc(1, 3, 3, 4'h0);
    cur_tag = "R11";
    idle(1, 2, 4'h0);
    idle(1, 3, 4'h0);

    cur_tag = "R4";
    cyc(1, 1, 8'h01, 4'h0);                 // source 1, start level 0
    cur_tag = "R5";
    cyc(1, 0, 8'h01, 4'h0);
    cur_tag = "R2";
    idle(60, 3, 4'b0010);
    check("R2", "edge interval", last_iv, 12);

    cur_tag = "R4";                         // unselected sources toggle only
    idle(20, 2, 4'b1101);
    cur_tag = "R1";
    rnd(40, 3);
    cur_tag = "R11";
    rnd(20, -1);

    cur_tag = "R10";                        // running writes: reload only
    cyc(1, 2, 0, 4'b0010);
    cyc(1, 3, 1, 4'b0010);
    rnd(40, -1);

    cur_tag = "R8";
    cyc(1, 1, 8'h09, 4'b0010);
    idle(20, 3, 4'b0010);
    cur_tag = "R9";
    cyc(1, 1, 8'h15, 4'b0010);
    idle(20, 2, 4'b0010);
    cur_tag = "R7";
    cyc(1, 1, 8'h05, 4'b0000);
    idle(2, 1, 4'b0000);
    check("R7", "start level shown", int'(pulse_out), 1);

    cur_tag = "R5";                         // stop holds counts
    cyc(1, 0, 8'h00, 4'b1111);
    idle(10, 2, 4'b1111);
    idle(2, 0, 4'b1111);
    cyc(1, 0, 8'h01, 4'b0000);
    rnd(25, 3);

    cur_tag = "R6";                         // forced stop wins over start
    cyc(1, 0, 8'h03, 4'b0010);
    idle(4, 0, 4'b0010);
    check("R6", "run after halt", int'(bus_rdata), 0);
    idle(3, 2, 4'b0010);
    idle(3, 3, 4'b0010);

    cur_tag = "R3";                         // n=0,m=0: underflow every tick
    cyc(1, 2, 0, 4'h0);
    cyc(1, 3, 0, 4'h0);
    cyc(1, 1, 8'h0B, 4'h0);
    cyc(1, 0, 8'h01, 4'h0);
    idle(20, 3, 4'b1000);
    rnd(30, -1);

    done = 1;
    summary();
    $finish;
  end
endmodule